// File: doc/BRIEF.md
# Burst Register Access Engine

This block sits between a serial control-port front end and a register file. The front end hands it bytes that have already been deserialized. At the start of each transaction the engine takes two bytes as a 16-bit register subaddress. Every byte after that is data.

For writes, the engine assembles each register word and sends it to the register file in one write pulse. For reads, it returns one byte per request. After each complete word it steps the subaddress by one, so a master can stream through contiguous registers without sending the address again.

Register widths are not uniform. The clock-synthesizer control register at 0x4002 holds six bytes, and every other location holds one. A small set of unmapped holes behaves like one-byte registers that discard writes and read as zero. While the master clock is reported invalid, only the two clock-setup registers, 0x4000 and 0x4002, may be written. A transaction end forces the next transaction to supply a fresh subaddress.

Top module: `regburst_engine`

## Requirements
- R1: After reset or a transaction end, the first two `byte_vld` bytes form the subaddress, high byte first. The direction flag does not affect them.
- R2: Each completed data word, read or write, increments the subaddress by 1. Bursts continue this way until the transaction ends.
- R3: The word at 0x4002 is six bytes long. All six bytes are committed by a single write, with the first received byte in `rf_wdata[47:40]`. Every other word is one byte, placed in `rf_wdata[7:0]` with the upper bits zero.
- R4: The holes are 0x4001, 0x4003 to 0x4007, 0x402E and 0x4032 to 0x4035. Each is a one-byte word: a write raises no `rf_we`, a read returns 0x00, and the subaddress still advances.
- R5: While `mclk_ok` is low at a word's final byte, a write is issued only to 0x4000 or 0x4002. Other writes are dropped, but the byte count and subaddress still advance.
- R6: A `xact_end` pulse returns the engine to subaddress collection and discards any partly gathered six-byte word. A data byte in the same cycle as `xact_end` is processed first.
- R7: A `rd_req` in the data phase with `rw_read` high produces a one-cycle `rd_vld` on the next cycle, with the byte in `rd_data`. A one-byte register supplies `rf_rdata[7:0]`. The six-byte register supplies its bytes most significant first, starting at `rf_rdata[47:40]`.
- R8: In the data phase, `byte_vld` is ignored while `rw_read` is high, and `rd_req` is ignored while `rw_read` is low.
- R9: `rf_we` is a one-cycle pulse in the cycle after the word's final byte is sampled. It is low after reset, as are `rd_vld` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| rd_req | input | 1 | Front end requests the next read byte |
| rw_read | input | 1 | Transaction direction, 1 = read |
| xact_end | input | 1 | Transaction-end pulse |
| mclk_ok | input | 1 | Master clock valid |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 16 | Register-file write address |
| rf_wdata | output | 48 | Register-file write word |
| rf_raddr | output | 16 | Register-file read address (current subaddress) |
| rf_rdata | input | 48 | Register-file read word for rf_raddr |
| rd_vld | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |

## Verification
The word-completion step and the transaction-end reset can fall in the same cycle. This happens when `xact_end` arrives together with the final byte of a word. The bench provokes it by pulsing `xact_end` alongside a one-byte write. It then judges the result two ways: the write must still reach the register file, and the next transaction's first two bytes must be taken as a fresh subaddress rather than as data. A second coincidence is a clock-invalid drop landing on a word's final byte in mid-burst. The bench checks that the following word still lands at the next address.

// File: rtl/regburst_pkg.sv
package regburst_pkg;
  localparam int unsigned SUB_W      = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WIDE_BYTES = 6;
  localparam int unsigned WIDE_W     = BYTE_W * WIDE_BYTES;
  localparam int unsigned CNT_W      = $clog2(WIDE_BYTES);
  localparam int unsigned STAGE_W    = WIDE_W - BYTE_W;

  localparam logic [SUB_W-1:0] CTRL0_ADDR = 16'h4000;
  localparam logic [SUB_W-1:0] WIDE_ADDR  = 16'h4002;

  typedef enum logic [1:0] {
    PH_SUB_HI = 2'd0,
    PH_SUB_LO = 2'd1,
    PH_DATA   = 2'd2
  } phase_t;

  function automatic logic in_span(logic [SUB_W-1:0] a,
                                   logic [SUB_W-1:0] lo,
                                   logic [SUB_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Unmapped locations inside the register window
  function automatic logic is_hole(logic [SUB_W-1:0] a);
    return (a == 16'h4001) || in_span(a, 16'h4003, 16'h4007) ||
           (a == 16'h402E) || in_span(a, 16'h4032, 16'h4035);
  endfunction

  // Index of the final byte of the word at address a
  function automatic logic [CNT_W-1:0] last_idx(logic [SUB_W-1:0] a);
    return (a == WIDE_ADDR) ? CNT_W'(WIDE_BYTES - 1) : '0;
  endfunction

  function automatic logic wr_allowed(logic [SUB_W-1:0] a, logic clk_ok);
    return !is_hole(a) && (clk_ok || (a == CTRL0_ADDR) || (a == WIDE_ADDR));
  endfunction

  // Byte lane of rf_rdata holding byte number cnt (most significant first)
  function automatic logic [CNT_W-1:0] lane_of(logic [SUB_W-1:0] a,
                                               logic [CNT_W-1:0] cnt);
    return last_idx(a) - cnt;
  endfunction
endpackage

// File: rtl/regburst_addr_track.sv
module regburst_addr_track
  import regburst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              rd_req,
  input  logic              rw_read,
  input  logic              xact_end,
  output phase_t            phase_q,
  output logic [SUB_W-1:0]  sub_addr_q,
  output logic [CNT_W-1:0]  byte_cnt_q,
  output logic              step_wr,
  output logic              step_rd,
  output logic              word_last,
  output logic              word_done
);
  logic in_data;

  always_comb begin
    in_data   = (phase_q == PH_DATA);
    step_wr   = in_data && byte_vld && !rw_read;
    step_rd   = in_data && rd_req && rw_read;
    word_last = (byte_cnt_q == last_idx(sub_addr_q));
    word_done = (step_wr || step_rd) && word_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_SUB_HI;
      sub_addr_q <= '0;
      byte_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_SUB_HI: if (byte_vld) begin
          sub_addr_q[SUB_W-1:BYTE_W] <= byte_data;
          phase_q                    <= PH_SUB_LO;
        end
        PH_SUB_LO: if (byte_vld) begin
          sub_addr_q[BYTE_W-1:0] <= byte_data;
          byte_cnt_q             <= '0;
          phase_q                <= PH_DATA;
        end
        PH_DATA: if (step_wr || step_rd) begin
          if (word_last) begin
            sub_addr_q <= sub_addr_q + SUB_W'(1);
            byte_cnt_q <= '0;
          end else begin
            byte_cnt_q <= byte_cnt_q + CNT_W'(1);
          end
        end
        default: phase_q <= PH_SUB_HI;
      endcase
      if (xact_end) begin
        phase_q    <= PH_SUB_HI;
        byte_cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/regburst_wr_path.sv
module regburst_wr_path
  import regburst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_wr,
  input  logic              word_last,
  input  logic              xact_end,
  input  logic              mclk_ok,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [SUB_W-1:0]  sub_addr,
  output logic              rf_we,
  output logic [SUB_W-1:0]  rf_waddr,
  output logic [WIDE_W-1:0] rf_wdata,
  output logic              wr_drop
);
  logic [STAGE_W-1:0] stage_q;
  logic               commit_ok;
  logic               is_wide;

  always_comb begin
    commit_ok = wr_allowed(sub_addr, mclk_ok);
    is_wide   = (last_idx(sub_addr) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we    <= 1'b0;
      wr_drop  <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      stage_q  <= '0;
    end else begin
      rf_we   <= 1'b0;
      wr_drop <= 1'b0;
      if (step_wr) begin
        if (word_last) begin
          rf_waddr <= sub_addr;
          rf_wdata <= is_wide ? {stage_q, byte_data}
                              : {{STAGE_W{1'b0}}, byte_data};
          rf_we    <= commit_ok;
          wr_drop  <= !commit_ok;
        end else begin
          stage_q <= {stage_q[STAGE_W-BYTE_W-1:0], byte_data};
        end
      end else if (xact_end) begin
        stage_q <= '0;
      end
    end
  end
endmodule

// File: rtl/regburst_rd_path.sv
module regburst_rd_path
  import regburst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_rd,
  input  logic [SUB_W-1:0]  sub_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [WIDE_W-1:0] rf_rdata,
  output logic              rd_vld,
  output logic [BYTE_W-1:0] rd_data
);
  logic [CNT_W-1:0]  lane;
  logic [BYTE_W-1:0] picked;

  always_comb begin
    lane   = lane_of(sub_addr, byte_cnt);
    picked = rf_rdata[int'(lane)*BYTE_W +: BYTE_W];
    if (is_hole(sub_addr)) picked = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= step_rd;
      if (step_rd) rd_data <= picked;
    end
  end
endmodule

// File: rtl/regburst_engine.sv
module regburst_engine
  import regburst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        rd_req,
  input  logic        rw_read,
  input  logic        xact_end,
  input  logic        mclk_ok,
  output logic        rf_we,
  output logic [15:0] rf_waddr,
  output logic [47:0] rf_wdata,
  output logic [15:0] rf_raddr,
  input  logic [47:0] rf_rdata,
  output logic        rd_vld,
  output logic [7:0]  rd_data
);
  phase_t             phase_q;
  logic [SUB_W-1:0]   sub_addr_q;
  logic [CNT_W-1:0]   byte_cnt_q;
  logic               step_wr;
  logic               step_rd;
  logic               word_last;
  logic               word_done;
  logic               wr_drop;
  logic               hole_now;

  assign hole_now = is_hole(sub_addr_q);
  assign rf_raddr = sub_addr_q;

  regburst_addr_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .rd_req     (rd_req),
    .rw_read    (rw_read),
    .xact_end   (xact_end),
    .phase_q    (phase_q),
    .sub_addr_q (sub_addr_q),
    .byte_cnt_q (byte_cnt_q),
    .step_wr    (step_wr),
    .step_rd    (step_rd),
    .word_last  (word_last),
    .word_done  (word_done)
  );

  regburst_wr_path u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_wr   (step_wr),
    .word_last (word_last),
    .xact_end  (xact_end),
    .mclk_ok   (mclk_ok),
    .byte_data (byte_data),
    .sub_addr  (sub_addr_q),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .wr_drop   (wr_drop)
  );

  regburst_rd_path u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_rd  (step_rd),
    .sub_addr (sub_addr_q),
    .byte_cnt (byte_cnt_q),
    .rf_rdata (rf_rdata),
    .rd_vld   (rd_vld),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/regburst_checker.sv
module regburst_checker
  import regburst_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             rd_req,
  input logic             rw_read,
  input logic             xact_end,
  input logic             mclk_ok,
  input logic             rf_we,
  input logic [SUB_W-1:0] rf_waddr,
  input logic             rd_vld,
  input logic [7:0]       rd_data,
  input phase_t           phase_q,
  input logic [SUB_W-1:0] sub_addr_q,
  input logic [CNT_W-1:0] byte_cnt_q,
  input logic             word_done,
  input logic             wr_drop,
  input logic             hole_now
);
  p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !xact_end) |=> (sub_addr_q == $past(sub_addr_q) + 16'd1));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt_q <= CNT_W'(WIDE_BYTES - 1));

  p_hole_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !is_hole(rf_waddr));

  p_hole_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && $past(hole_now)) |-> (rd_data == 8'h00));

  p_clk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !$past(mclk_ok)) |-> (rf_waddr == CTRL0_ADDR || rf_waddr == WIDE_ADDR));

  p_we_drop_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && wr_drop));

  p_end_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xact_end |=> (phase_q == PH_SUB_HI && byte_cnt_q == '0));

  p_rd_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_req && rw_read));

  p_we_follows_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(byte_vld && !rw_read));
endmodule

bind regburst_engine regburst_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld   (byte_vld),
  .rd_req     (rd_req),
  .rw_read    (rw_read),
  .xact_end   (xact_end),
  .mclk_ok    (mclk_ok),
  .rf_we      (rf_we),
  .rf_waddr   (rf_waddr),
  .rd_vld     (rd_vld),
  .rd_data    (rd_data),
  .phase_q    (phase_q),
  .sub_addr_q (sub_addr_q),
  .byte_cnt_q (byte_cnt_q),
  .word_done  (word_done),
  .wr_drop    (wr_drop),
  .hole_now   (hole_now)
);

// File: tb/regburst_engine_tb.sv
module regburst_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        rd_req = 1'b0;
  logic        rw_read = 1'b0;
  logic        xact_end = 1'b0;
  logic        mclk_ok = 1'b1;
  logic        rf_we;
  logic [15:0] rf_waddr;
  logic [47:0] rf_wdata;
  logic [15:0] rf_raddr;
  logic [47:0] rf_rdata;
  logic        rd_vld;
  logic [7:0]  rd_data;

  int vec = 0;
  int bad = 0;
  logic [15:0] m_addr;
  int          m_cnt;
  logic [39:0] m_acc;

  always #4 clk = ~clk;

  regburst_engine u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .rd_req(rd_req), .rw_read(rw_read), .xact_end(xact_end), .mclk_ok(mclk_ok),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rd_vld(rd_vld), .rd_data(rd_data)
  );

  // Register-file contents: byte k (most significant first) = low address byte ^ 0x11*(k+1)
  function automatic logic [47:0] pat(logic [15:0] a);
    logic [47:0] p;
    for (int k = 0; k < 6; k++) p[47-8*k -: 8] = a[7:0] ^ (8'h11 * 8'(k + 1));
    return p;
  endfunction

  always_comb rf_rdata = pat(rf_raddr);

  function automatic bit tb_hole(logic [15:0] a);
    case (a)
      16'h4001, 16'h4003, 16'h4004, 16'h4005, 16'h4006, 16'h4007,
      16'h402E, 16'h4032, 16'h4033, 16'h4034, 16'h4035: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int tb_len(logic [15:0] a);
    return (a == 16'h4002) ? 6 : 1;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic raw_byte(logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = b;
    @(posedge clk);
    @(negedge clk);
    byte_vld = 1'b0;
    check(rf_we == 1'b0, "R1", 64'(rf_we), 64'd0);
  endtask

  task automatic begin_xact(logic [15:0] a, bit rd);
    rw_read = rd;
    raw_byte(a[15:8]);
    raw_byte(a[7:0]);
    m_addr = a; m_cnt = 0;
  endtask

  task automatic end_xact();
    @(negedge clk);
    xact_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    xact_end = 1'b0;
    m_cnt = 0;
  endtask

  task automatic put_byte(logic [7:0] b, bit endnow);
    bit exp_we;
    logic [47:0] exp_d;
    @(negedge clk);
    byte_vld = 1'b1; byte_data = b; xact_end = endnow;
    @(posedge clk);
    @(negedge clk);
    byte_vld = 1'b0; xact_end = 1'b0;
    if (m_cnt == tb_len(m_addr) - 1) begin
      exp_we = !tb_hole(m_addr) &&
               (mclk_ok || m_addr == 16'h4000 || m_addr == 16'h4002);
      exp_d  = (tb_len(m_addr) == 6) ? {m_acc, b} : {40'd0, b};
      check(rf_we == exp_we, mclk_ok ? "R4" : "R5", 64'(rf_we), 64'(exp_we));
      if (exp_we) begin
        check(rf_waddr == m_addr, "R2", 64'(rf_waddr), 64'(m_addr));
        check(rf_wdata == exp_d, "R3", 64'(rf_wdata), 64'(exp_d));
      end
      m_addr = m_addr + 16'd1; m_cnt = 0;
    end else begin
      check(rf_we == 1'b0, "R3", 64'(rf_we), 64'd0);
      m_acc = {m_acc[31:0], b};
      m_cnt++;
    end
    if (endnow) m_cnt = 0;
  endtask

  task automatic get_byte();
    logic [7:0] exp_b;
    @(negedge clk);
    rd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    if (tb_hole(m_addr)) exp_b = 8'h00;
    else if (tb_len(m_addr) == 6) exp_b = m_addr[7:0] ^ (8'h11 * 8'(m_cnt + 1));
    else exp_b = m_addr[7:0] ^ 8'h66;
    check(rd_vld == 1'b1, "R7", 64'(rd_vld), 64'd1);
    check(rd_data == exp_b, tb_hole(m_addr) ? "R4" : "R7", 64'(rd_data), 64'(exp_b));
    if (m_cnt == tb_len(m_addr) - 1) begin m_addr = m_addr + 16'd1; m_cnt = 0; end
    else m_cnt++;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    m_acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(rf_we == 1'b0, "R9", 64'(rf_we), 64'd0);
    check(rd_vld == 1'b0, "R9", 64'(rd_vld), 64'd0);
    check(rd_data == 8'h00, "R9", 64'(rd_data), 64'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: write sweep over the window with a valid clock
    mclk_ok = 1'b1;
    begin_xact(16'h4000, 1'b0);
    for (int i = 0; i < 70; i++) put_byte(8'(i) ^ 8'h5A, 1'b0);
    end_xact();

    // R5: same sweep with the clock invalid
    mclk_ok = 1'b0;
    begin_xact(16'h4000, 1'b0);
    for (int i = 0; i < 70; i++) put_byte(8'(i) ^ 8'hC3, 1'b0);
    end_xact();

    // R5: clock drops in mid-burst across holes
    mclk_ok = 1'b1;
    begin_xact(16'h402C, 1'b0);
    put_byte(8'h11, 1'b0);
    mclk_ok = 1'b0;
    for (int i = 0; i < 9; i++) put_byte(8'h20 + 8'(i), 1'b0);
    mclk_ok = 1'b1;
    put_byte(8'h77, 1'b0);
    end_xact();

    // R7 R4: read sweep
    begin_xact(16'h4000, 1'b1);
    for (int i = 0; i < 70; i++) get_byte();
    end_xact();

    // R8: stray byte_vld during a read is ignored
    begin_xact(16'h4010, 1'b1);
    get_byte();
    @(negedge clk); byte_vld = 1'b1; byte_data = 8'hEE;
    @(posedge clk); @(negedge clk); byte_vld = 1'b0;
    check(rf_we == 1'b0, "R8", 64'(rf_we), 64'd0);
    get_byte();
    end_xact();

    // R8: stray rd_req during a write is ignored
    begin_xact(16'h4020, 1'b0);
    @(negedge clk); rd_req = 1'b1;
    @(posedge clk); @(negedge clk); rd_req = 1'b0;
    check(rd_vld == 1'b0, "R8", 64'(rd_vld), 64'd0);
    put_byte(8'h3C, 1'b0);
    end_xact();

    // R6: end in the same cycle as a word's final byte, then fresh subaddress
    begin_xact(16'h4010, 1'b0);
    put_byte(8'hA1, 1'b0);
    put_byte(8'hA2, 1'b1);
    begin_xact(16'h4020, 1'b0);
    put_byte(8'hA3, 1'b0);
    end_xact();

    // R6 R3: interrupted six-byte word is discarded, then written whole
    begin_xact(16'h4002, 1'b0);
    for (int i = 0; i < 3; i++) put_byte(8'h90 + 8'(i), 1'b0);
    end_xact();
    check(rf_we == 1'b0, "R6", 64'(rf_we), 64'd0);
    begin_xact(16'h4002, 1'b0);
    for (int i = 0; i < 7; i++) put_byte(8'hB0 + 8'(i), 1'b0);
    end_xact();

    // R6 R7: interrupted six-byte read restarts at its first byte
    begin_xact(16'h4002, 1'b1);
    get_byte(); get_byte();
    end_xact();
    begin_xact(16'h4002, 1'b1);
    for (int i = 0; i < 7; i++) get_byte();
    end_xact();

    summary();
  end
endmodule